// File: doc/BRIEF.md
# GPIO Pin Configuration and Interrupt Bank

This block is a bank of identical GPIO pin slices behind one memory-mapped register window. Each slice has four 32-bit registers. A control word selects the pad function, pull, drive strength and output enable. An I/O word returns the synchronized input and sets the output level. A configuration word sets up interrupt detection. A status word holds the pending interrupt.

Each pad input passes through a synchronizer chain. A detector then turns the input into an event. In level mode the event follows the active level. In the three edge modes it fires on a change of the input, with the polarity taken into account. A pending event sets a sticky status bit. Software clears that bit by writing zero to it. The status gated by the enable drives the per-pin interrupt line.

A routing field in the configuration word picks a destination. Pins whose field equals the application processor code feed a combined interrupt output. The register bus is plain: an address, a write strobe, write data, and read data that is valid in the same cycle.

Top module: `gpio_irq_bank`

## Requirements
- R1: Pin n (0 ≤ n < NUM_PINS) decodes at BASE_ADDR + 0x10·n. Address bits [3:2] select the register: 0 control, 1 I/O, 2 interrupt configuration, 3 status. Address bits [1:0] are ignored. An address outside the window reads 0, and a write to it changes nothing.
- R2: The control word holds pull in bits [1:0], function select in bits [5:2], drive strength in bits [8:6] and output enable in bit 9. These fields read back and appear on the pad field outputs. All other bits read 0.
- R3: pad_oe_o of a pin is 1 only when its function select is 0 and its output enable bit is 1.
- R4: In the I/O word, bit 1 is a read/write output level that drives pad_out_o. Bit 0 is read-only and returns the pad input after SYNC_STAGES clock edges, which is 2 by default.
- R5: Detection mode is configuration bits [3:2]; 0 selects level mode. Polarity is bit 1. In level mode, polarity 1 gives an event in every cycle the synchronized input is 1, and polarity 0 gives one in every cycle it is 0.
- R6: Mode 1 fires on a 0→1 change of the polarity-adjusted input. Mode 2 fires on a 1→0 change of it. Mode 3 fires on either change. The polarity-adjusted input is the input itself when polarity is 1 and its inverse when polarity is 0.
- R7: The status is bit 0 of the status word and is set by an event. Writing 0 to that bit clears it. Writing 1 has no effect. An event in the same cycle as a clearing write leaves the status set.
- R8: Configuration bit 0 is the enable. irq_o of a pin is its status AND its enable. Configuration bit 4 reads the status whatever the enable is.
- R9: Configuration bits [5 +: TARGET_W] hold the routing target. app_irq_o is 1 when some pin has irq_o set and a target equal to APP_TARGET, which defaults to 3.
- R10: While rst_n is low, every register reads 0 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| pad_in_i | input | NUM_PINS | Asynchronous pad input levels |
| pad_out_o | output | NUM_PINS | Pad output levels |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| pad_pull_o | output | 2·NUM_PINS | Pull select per pin |
| pad_func_o | output | 4·NUM_PINS | Function select per pin |
| pad_drive_o | output | 3·NUM_PINS | Drive strength per pin |
| irq_o | output | NUM_PINS | Per-pin enabled interrupt |
| irq_target_o | output | TARGET_W·NUM_PINS | Routing target per pin |
| app_irq_o | output | 1 | Combined interrupt for the application processor |

## Verification
The bench builds the bank with NUM_PINS = 4, ADDR_W = 16, BASE_ADDR = 0x1000, SYNC_STAGES = 2, TARGET_W = 3 and APP_TARGET = 3. With four pins, each of the four detection modes can run on its own pin at once, and the first address past the window (0x1040) falls within the tested range. Two synchronizer stages make the latency from input to status three edges, and the bench probes both sides of that latency. A three-bit target allows routing to APP_TARGET and to a neighbouring code, so the combined output is checked in both the routed and the unrouted case.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

   // register select, taken from address bits [3:2]
   typedef enum logic [1:0] {
      REG_CTL  = 2'd0,
      REG_IO   = 2'd1,
      REG_CFG  = 2'd2,
      REG_STAT = 2'd3
   } reg_sel_e;

   // detection modes in configuration bits [3:2]
   typedef enum logic [1:0] {
      DET_LEVEL = 2'd0,
      DET_RISE  = 2'd1,
      DET_FALL  = 2'd2,
      DET_BOTH  = 2'd3
   } det_mode_e;

   localparam int SLOT_BYTES = 16;

   // control word layout
   localparam int PULL_LSB = 0;
   localparam int PULL_W   = 2;
   localparam int FUNC_LSB = 2;
   localparam int FUNC_W   = 4;
   localparam int DRV_LSB  = 6;
   localparam int DRV_W    = 3;
   localparam int OE_BIT   = 9;

   // I/O word layout
   localparam int IO_IN_BIT  = 0;
   localparam int IO_OUT_BIT = 1;

   // configuration word layout
   localparam int CFG_EN_BIT  = 0;
   localparam int CFG_POL_BIT = 1;
   localparam int CFG_DET_LSB = 2;
   localparam int CFG_RAW_BIT = 4;
   localparam int CFG_TGT_LSB = 5;

   // status word layout
   localparam int STAT_BIT = 0;

endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

   initial begin
      assert (STAGES >= 2) else $error("gpio_irq_sync: STAGES must be at least 2");
   end
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
   import gpio_irq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl,
   input  logic      pol,
   input  det_mode_e mode,
   output logic      evt
);
   logic prev_q;
   logic adj_now, adj_prev, rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   // polarity applied to both samples so a polarity change is not an edge
   assign adj_now  = pol ? lvl    : ~lvl;
   assign adj_prev = pol ? prev_q : ~prev_q;
   assign rise     = adj_now & ~adj_prev;
   assign fall     = ~adj_now & adj_prev;

   always_comb begin
      unique case (mode)
         DET_LEVEL: evt = adj_now;
         DET_RISE:  evt = rise;
         DET_FALL:  evt = fall;
         DET_BOTH:  evt = rise | fall;
         default:   evt = 1'b0;
      endcase
   end

   // R6: an edge-mode event needs a change of the sampled input
   p_edge_needs_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != DET_LEVEL && evt) |-> (lvl != prev_q));
endmodule

// File: rtl/gpio_irq_pin.sv
`timescale 1ns/1ps
module gpio_irq_pin
   import gpio_irq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int TARGET_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  reg_sel_e            wsel,
   input  logic [31:0]         wdata,
   input  reg_sel_e            rsel,
   output logic [31:0]         rdata,
   input  logic                pad_in,
   output logic                pad_out,
   output logic                pad_oe,
   output logic [PULL_W-1:0]   pull,
   output logic [FUNC_W-1:0]   func,
   output logic [DRV_W-1:0]    drive,
   output logic                irq,
   output logic [TARGET_W-1:0] target
);
   logic wr_ctl, wr_io, wr_cfg, wr_stat;
   logic [PULL_W-1:0]   pull_q;
   logic [FUNC_W-1:0]   func_q;
   logic [DRV_W-1:0]    drv_q;
   logic                oe_q, out_q, en_q, pol_q, stat_q;
   det_mode_e           det_q;
   logic [TARGET_W-1:0] tgt_q;
   logic                lvl, evt;

   assign wr_ctl  = wr_en && (wsel == REG_CTL);
   assign wr_io   = wr_en && (wsel == REG_IO);
   assign wr_cfg  = wr_en && (wsel == REG_CFG);
   assign wr_stat = wr_en && (wsel == REG_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pull_q <= '0;
         func_q <= '0;
         drv_q  <= '0;
         oe_q   <= 1'b0;
      end else if (wr_ctl) begin
         pull_q <= wdata[PULL_LSB +: PULL_W];
         func_q <= wdata[FUNC_LSB +: FUNC_W];
         drv_q  <= wdata[DRV_LSB +: DRV_W];
         oe_q   <= wdata[OE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     out_q <= 1'b0;
      else if (wr_io) out_q <= wdata[IO_OUT_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         pol_q <= 1'b0;
         det_q <= DET_LEVEL;
         tgt_q <= '0;
      end else if (wr_cfg) begin
         en_q  <= wdata[CFG_EN_BIT];
         pol_q <= wdata[CFG_POL_BIT];
         det_q <= det_mode_e'(wdata[CFG_DET_LSB +: 2]);
         tgt_q <= wdata[CFG_TGT_LSB +: TARGET_W];
      end
   end

   gpio_irq_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (lvl)
   );

   gpio_irq_detect detect_i (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .pol   (pol_q),
      .mode  (det_q),
      .evt   (evt)
   );

   // an event outranks a clearing write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         stat_q <= 1'b0;
      else if (evt)                       stat_q <= 1'b1;
      else if (wr_stat && !wdata[STAT_BIT]) stat_q <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      unique case (rsel)
         REG_CTL: begin
            rdata[PULL_LSB +: PULL_W] = pull_q;
            rdata[FUNC_LSB +: FUNC_W] = func_q;
            rdata[DRV_LSB +: DRV_W]   = drv_q;
            rdata[OE_BIT]             = oe_q;
         end
         REG_IO: begin
            rdata[IO_IN_BIT]  = lvl;
            rdata[IO_OUT_BIT] = out_q;
         end
         REG_CFG: begin
            rdata[CFG_EN_BIT]                = en_q;
            rdata[CFG_POL_BIT]               = pol_q;
            rdata[CFG_DET_LSB +: 2]          = det_q;
            rdata[CFG_RAW_BIT]               = stat_q;
            rdata[CFG_TGT_LSB +: TARGET_W]   = tgt_q;
         end
         REG_STAT: rdata[STAT_BIT] = stat_q;
         default:  rdata = '0;
      endcase
   end

   assign pad_out = out_q;
   assign pad_oe  = oe_q && (func_q == '0);
   assign pull    = pull_q;
   assign func    = func_q;
   assign drive   = drv_q;
   assign irq     = stat_q && en_q;
   assign target  = tgt_q;

   // R7: any event leaves the status set on the next edge
   p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> stat_q);
   // R7: a zero write with no competing event clears the status
   p_zero_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !wdata[STAT_BIT] && !evt) |=> !stat_q);
   // R7: the status never rises without an event
   p_no_rise_without_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt && !stat_q) |=> !stat_q);
   // R8: the interrupt line needs the enable
   p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (en_q && stat_q));
   // R3: output enable only in plain GPIO function
   p_oe_plain_gpio_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe |-> (func_q == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
   import gpio_irq_pkg::*;
#(
   parameter int          NUM_PINS    = 4,
   parameter int          ADDR_W      = 16,
   parameter int unsigned BASE_ADDR   = 32'h1000,
   parameter int          SYNC_STAGES = 2,
   parameter int          TARGET_W    = 3,
   parameter int          APP_TARGET  = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic                         bus_wr_en,
   input  logic [31:0]                  bus_wdata,
   output logic [31:0]                  bus_rdata,
   input  logic [NUM_PINS-1:0]          pad_in_i,
   output logic [NUM_PINS-1:0]          pad_out_o,
   output logic [NUM_PINS-1:0]          pad_oe_o,
   output logic [NUM_PINS*PULL_W-1:0]   pad_pull_o,
   output logic [NUM_PINS*FUNC_W-1:0]   pad_func_o,
   output logic [NUM_PINS*DRV_W-1:0]    pad_drive_o,
   output logic [NUM_PINS-1:0]          irq_o,
   output logic [NUM_PINS*TARGET_W-1:0] irq_target_o,
   output logic                         app_irq_o
);
   localparam int              SLOT_LG = $clog2(SLOT_BYTES);
   localparam int              SLOT_W  = ADDR_W - SLOT_LG;
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

   initial begin
      assert (NUM_PINS >= 1) else $error("gpio_irq_bank: NUM_PINS must be at least 1");
      assert (ADDR_W > SLOT_LG && ADDR_W <= 32) else $error("gpio_irq_bank: ADDR_W out of range");
      assert ((BASE_ADDR % SLOT_BYTES) == 0) else $error("gpio_irq_bank: BASE_ADDR not slot aligned");
      assert ((longint'(BASE_ADDR) + longint'(NUM_PINS) * SLOT_BYTES) <= (longint'(1) << ADDR_W))
         else $error("gpio_irq_bank: register window exceeds address space");
      assert (TARGET_W >= 1 && CFG_TGT_LSB + TARGET_W <= 32) else $error("gpio_irq_bank: TARGET_W out of range");
      assert (APP_TARGET >= 0 && APP_TARGET < (1 << TARGET_W)) else $error("gpio_irq_bank: APP_TARGET does not fit");
   end

   logic [ADDR_W-1:0] off;
   logic [SLOT_W-1:0] slot;
   logic              hit;
   reg_sel_e          sel;
   logic [31:0]       pin_rdata [NUM_PINS];
   logic [NUM_PINS-1:0] to_app;

   assign off  = bus_addr - BASE_V;
   assign slot = off[ADDR_W-1:SLOT_LG];
   assign hit  = (bus_addr >= BASE_V) && (slot < SLOT_W'(NUM_PINS));
   assign sel  = reg_sel_e'(off[3:2]);

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      logic pin_wr;
      assign pin_wr = bus_wr_en && hit && (slot == SLOT_W'(g));

      gpio_irq_pin #(
         .SYNC_STAGES (SYNC_STAGES),
         .TARGET_W    (TARGET_W)
      ) pin_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (pin_wr),
         .wsel    (sel),
         .wdata   (bus_wdata),
         .rsel    (sel),
         .rdata   (pin_rdata[g]),
         .pad_in  (pad_in_i[g]),
         .pad_out (pad_out_o[g]),
         .pad_oe  (pad_oe_o[g]),
         .pull    (pad_pull_o[g*PULL_W +: PULL_W]),
         .func    (pad_func_o[g*FUNC_W +: FUNC_W]),
         .drive   (pad_drive_o[g*DRV_W +: DRV_W]),
         .irq     (irq_o[g]),
         .target  (irq_target_o[g*TARGET_W +: TARGET_W])
      );

      assign to_app[g] = irq_o[g] && (irq_target_o[g*TARGET_W +: TARGET_W] == TARGET_W'(APP_TARGET));
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (hit && (slot == SLOT_W'(i))) bus_rdata = pin_rdata[i];
      end
   end

   assign app_irq_o = |to_app;

   // R9: the combined line needs at least one pin interrupt
   p_app_needs_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
      app_irq_o |-> (irq_o != '0));
   // R10: pads are not driven in the first cycle after reset
   p_quiet_after_reset_r10: assert property (@(posedge clk)
      !rst_n |=> (pad_oe_o == '0));
endmodule

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb_top;
   localparam int NP = 4;
   localparam int TW = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_wr_en = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NP-1:0]    pad_in_i = '0;
   logic [NP-1:0]    pad_out_o, pad_oe_o, irq_o;
   logic [NP*2-1:0]  pad_pull_o;
   logic [NP*4-1:0]  pad_func_o;
   logic [NP*3-1:0]  pad_drive_o;
   logic [NP*TW-1:0] irq_target_o;
   logic             app_irq_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gpio_irq_bank #(
      .NUM_PINS(NP), .ADDR_W(16), .BASE_ADDR(32'h1000),
      .SYNC_STAGES(2), .TARGET_W(TW), .APP_TARGET(3)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in_i(pad_in_i),
      .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .pad_pull_o(pad_pull_o),
      .pad_func_o(pad_func_o), .pad_drive_o(pad_drive_o), .irq_o(irq_o),
      .irq_target_o(irq_target_o), .app_irq_o(app_irq_o)
   );

   // behavioural reference state, one entry per pin
   int m_pull[NP], m_func[NP], m_drv[NP], m_oe[NP], m_out[NP];
   int m_en[NP], m_pol[NP], m_det[NP], m_tgt[NP], m_st[NP];
   int m_s1[NP], m_s2[NP], m_prev[NP];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [15:0] a);
      int off, p, r;
      logic [31:0] v;
      off = int'(a) - 4096;
      if (off < 0 || off >= NP * 16) return 32'h0;
      p = off / 16;
      r = (off / 4) % 4;
      case (r)
         0: v = 32'(m_pull[p] + m_func[p] * 4 + m_drv[p] * 64 + m_oe[p] * 512);
         1: v = 32'(m_s2[p] + m_out[p] * 2);
         2: v = 32'(m_en[p] + m_pol[p] * 2 + m_det[p] * 4 + m_st[p] * 16 + m_tgt[p] * 32);
         default: v = 32'(m_st[p]);
      endcase
      return v;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NP; p++) begin
            m_pull[p] = 0; m_func[p] = 0; m_drv[p] = 0; m_oe[p] = 0; m_out[p] = 0;
            m_en[p] = 0; m_pol[p] = 0; m_det[p] = 0; m_tgt[p] = 0; m_st[p] = 0;
            m_s1[p] = 0; m_s2[p] = 0; m_prev[p] = 0;
         end
      end else begin
         int off, wp, wr;
         bit hitw, ev, a_now, a_prev;
         off  = int'(bus_addr) - 4096;
         hitw = bus_wr_en && off >= 0 && off < NP * 16;
         wp   = off / 16;
         wr   = (off / 4) % 4;
         for (int p = 0; p < NP; p++) begin
            a_now  = (m_pol[p] != 0) ? (m_s2[p] != 0)   : (m_s2[p] == 0);
            a_prev = (m_pol[p] != 0) ? (m_prev[p] != 0) : (m_prev[p] == 0);
            case (m_det[p])
               0: ev = a_now;
               1: ev = a_now && !a_prev;
               2: ev = !a_now && a_prev;
               default: ev = a_now != a_prev;
            endcase
            if (ev) m_st[p] = 1;
            else if (hitw && wp == p && wr == 3 && !bus_wdata[0]) m_st[p] = 0;
            if (hitw && wp == p) begin
               case (wr)
                  0: begin
                     m_pull[p] = int'(bus_wdata[1:0]); m_func[p] = int'(bus_wdata[5:2]);
                     m_drv[p] = int'(bus_wdata[8:6]); m_oe[p] = int'(bus_wdata[9]);
                  end
                  1: m_out[p] = int'(bus_wdata[1]);
                  2: begin
                     m_en[p] = int'(bus_wdata[0]); m_pol[p] = int'(bus_wdata[1]);
                     m_det[p] = int'(bus_wdata[3:2]); m_tgt[p] = int'(bus_wdata[7:5]);
                  end
                  default: ;
               endcase
            end
            m_prev[p] = m_s2[p];
            m_s2[p]   = m_s1[p];
            m_s1[p]   = int'(pad_in_i[p]);
         end
      end
   end

   // lockstep comparison on every falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [NP-1:0] e_irq, e_oe, e_out;
         logic [NP*2-1:0] e_pull;
         logic [NP*4-1:0] e_func;
         logic [NP*3-1:0] e_drv;
         logic [NP*TW-1:0] e_tgt;
         logic e_app;
         e_app = 1'b0;
         for (int p = 0; p < NP; p++) begin
            e_irq[p] = (m_st[p] != 0) && (m_en[p] != 0);
            e_oe[p]  = (m_oe[p] != 0) && (m_func[p] == 0);
            e_out[p] = m_out[p] != 0;
            e_pull[p*2 +: 2] = 2'(m_pull[p]);
            e_func[p*4 +: 4] = 4'(m_func[p]);
            e_drv[p*3 +: 3]  = 3'(m_drv[p]);
            e_tgt[p*TW +: TW] = TW'(m_tgt[p]);
            if (e_irq[p] && m_tgt[p] == 3) e_app = 1'b1;
         end
         chk("R1 read data", bus_rdata, exp_read(bus_addr));
         chk("R8 irq lines", 32'(irq_o), 32'(e_irq));
         chk("R9 app irq", 32'(app_irq_o), 32'(e_app));
         chk("R9 target fields", 32'(irq_target_o), 32'(e_tgt));
         chk("R3 output enables", 32'(pad_oe_o), 32'(e_oe));
         chk("R4 output levels", 32'(pad_out_o), 32'(e_out));
         chk("R2 pull fields", 32'(pad_pull_o), 32'(e_pull));
         chk("R2 function fields", 32'(pad_func_o), 32'(e_func));
         chk("R2 drive fields", 32'(pad_drive_o), 32'(e_drv));
      end
   end

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
      @(posedge clk); #2;
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [15:0] a, input logic [31:0] exp);
      @(posedge clk); #2;
      bus_addr = a;
      @(negedge clk);
      chk(tag, bus_rdata, exp);
   endtask

   task automatic rd_now(input string tag, input logic [15:0] a, input logic [31:0] exp);
      #1 bus_addr = a;
      #1 chk(tag, bus_rdata, exp);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic set_pad(input int p, input logic v);
      @(posedge clk); #2;
      pad_in_i[p] = v;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      // R10: register and output state while reset is held
      wait_cyc(2); #1;
      rd_now("R10 ctl in reset", 16'h1000, 32'h0);
      rd_now("R10 io in reset", 16'h1014, 32'h0);
      rd_now("R10 cfg in reset", 16'h1028, 32'h0);
      rd_now("R10 stat in reset", 16'h103C, 32'h0);
      chk("R10 irq in reset", 32'(irq_o), 32'h0);
      chk("R10 oe in reset", 32'(pad_oe_o), 32'h0);
      chk("R10 app irq in reset", 32'(app_irq_o), 32'h0);
      @(posedge clk); #2 rst_n = 1'b1;
      wait_cyc(4);

      // R2 control fields, upper bits discarded
      wr(16'h1000, 32'h8000_03C3);
      rd("R2 ctl readback", 16'h1000, 32'h0000_03C3);
      chk("R3 oe plain gpio", 32'(pad_oe_o[0]), 32'h1);
      wr(16'h1010, 32'h0000_0204);
      rd("R2 ctl alt function", 16'h1010, 32'h0000_0204);
      chk("R3 oe blocked by function", 32'(pad_oe_o[1]), 32'h0);

      // R1 out-of-window accesses
      wr(16'h1040, 32'hFFFF_FFFF);
      rd("R1 past window", 16'h1040, 32'h0);
      rd("R1 below window", 16'h0FF0, 32'h0);
      rd("R1 pin3 ctl untouched", 16'h1030, 32'h0);
      rd("R1 low addr bits ignored", 16'h1013, 32'h0000_0204);

      // R4 output and synchronized input
      wr(16'h1004, 32'h2);
      chk("R4 pad out", 32'(pad_out_o[0]), 32'h1);
      @(posedge clk); #2 pad_in_i[0] = 1'b1; bus_addr = 16'h1004;
      @(negedge clk); chk("R4 input before sync", bus_rdata, 32'h2);
      @(negedge clk); chk("R4 input one edge in", bus_rdata, 32'h2);
      @(negedge clk); chk("R4 input after two edges", bus_rdata, 32'h3);
      set_pad(0, 1'b0);
      wait_cyc(4);

      // R5 level mode, polarity high
      wr(16'h1008, 32'h3);
      wait_cyc(2);
      wr(16'h100C, 32'h0);
      rd("R5 idle level status", 16'h100C, 32'h0);
      set_pad(0, 1'b1);
      wait_cyc(4);
      rd("R5 active-high level", 16'h100C, 32'h1);
      chk("R8 irq with enable", 32'(irq_o[0]), 32'h1);
      wr(16'h100C, 32'h0);
      rd("R7 event beats clear", 16'h100C, 32'h1);
      set_pad(0, 1'b0);
      wait_cyc(4);
      wr(16'h100C, 32'h0);
      rd("R7 zero write clears", 16'h100C, 32'h0);
      wr(16'h100C, 32'h1);
      rd("R7 one write no effect", 16'h100C, 32'h0);
      // R5 level mode, polarity low
      wr(16'h1008, 32'h1);
      wait_cyc(2);
      rd("R5 active-low level", 16'h100C, 32'h1);
      wr(16'h1008, 32'h3);
      wait_cyc(2);
      wr(16'h100C, 32'h0);

      // R6 mode 1 on pin 1, polarity high
      wr(16'h1018, 32'h7);
      wr(16'h101C, 32'h0);
      set_pad(1, 1'b1);
      wait_cyc(5);
      rd("R6 rising caught", 16'h101C, 32'h1);
      wr(16'h101C, 32'h0);
      rd("R6 edge not repeated", 16'h101C, 32'h0);
      set_pad(1, 1'b0);
      wait_cyc(5);
      rd("R6 falling ignored by mode 1", 16'h101C, 32'h0);
      // R6 mode 2 on pin 2
      wr(16'h1028, 32'hB);
      wr(16'h102C, 32'h0);
      set_pad(2, 1'b1);
      wait_cyc(5);
      rd("R6 rising ignored by mode 2", 16'h102C, 32'h0);
      set_pad(2, 1'b0);
      wait_cyc(5);
      rd("R6 falling caught", 16'h102C, 32'h1);
      // R6 mode 3 on pin 3
      wr(16'h1038, 32'hF);
      wr(16'h103C, 32'h0);
      set_pad(3, 1'b1);
      wait_cyc(5);
      rd("R6 both: rise", 16'h103C, 32'h1);
      wr(16'h103C, 32'h0);
      set_pad(3, 1'b0);
      wait_cyc(5);
      rd("R6 both: fall", 16'h103C, 32'h1);
      // R6 mode 1 with polarity low catches falls
      wr(16'h1018, 32'h5);
      wr(16'h101C, 32'h0);
      set_pad(1, 1'b1);
      wait_cyc(5);
      rd("R6 inverted rise ignored", 16'h101C, 32'h0);
      set_pad(1, 1'b0);
      wait_cyc(5);
      rd("R6 inverted fall caught", 16'h101C, 32'h1);

      // R8 raw status visible with enable off
      wr(16'h1038, 32'hE);
      rd("R8 raw bit with enable off", 16'h1038, 32'h1E);
      chk("R8 irq masked", 32'(irq_o[3]), 32'h0);

      // R9 routing to the application processor
      wr(16'h1008, 32'hFFFF_FF63);
      set_pad(0, 1'b1);
      wait_cyc(4);
      @(negedge clk);
      chk("R9 app irq routed", 32'(app_irq_o), 32'h1);
      rd("R9 cfg with target", 16'h1008, 32'h73);
      wr(16'h1008, 32'h43);
      @(negedge clk);
      chk("R9 app irq unrouted", 32'(app_irq_o), 32'h0);
      chk("R9 pin irq still set", 32'(irq_o[0]), 32'h1);
      set_pad(0, 1'b0);
      wait_cyc(5);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule